// File: doc/BRIEF.md
# Sequenced Reset Release Controller

This block takes a subsystem out of reset in a controlled way. Nothing leaves reset until the clock-generation circuit reports a stable lock. The controller then holds every downstream module in reset for a programmable minimum time. After that it releases the modules one at a time, in ascending index order.

Each downstream module returns a flag that is high while its own state machine sits in its reset or initialisation state. The controller releases a module only after it has seen that module's flag. Only then does it move on to the next module.

A per-stage timeout ends the sequence in a sticky fault if a flag never arrives. The external reset request is an ordinary, synchronised input that restarts the sequencing machine. It is not a net fanned out to every flip-flop.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `clk_locked` is low, every bit of `stage_rst` is 1 (held in reset) from the next clock edge on. No stage is released before lock has been seen in the lock-wait state.
- R2: `rst_req` passes through a two-flop synchroniser. The sequencer reacts on the third rising edge after a change of `rst_req`. While the synchronised request is high, `stage_rst` is all ones and `all_ready` and `seq_error` are 0.
- R3: Bit i of `stage_rst` falls only on an edge where `stage_init_ack[i]` is 1 and stage i is the stage being served. A stage whose flag stays low is never released.
- R4: Stages are released in ascending index order, starting at index 0, with at most one stage released per clock edge.
- R5: Let L be the edge on which lock is first seen in the lock-wait state, and Heff = max(`hold_cycles`, 1). With every flag high, stage i is released on edge L+Heff+1+i.
- R6: Let Teff = max(`timeout_cycles`, 1). If the flag of stage f is still low on the Teff-th edge after the controller starts waiting for it, `seq_error` rises on that edge and all `stage_rst` bits return to 1. A stage f is served from edge L+Heff+f, so the fault appears on edge L+Heff+f+Teff. The fault persists through loss of lock until `rst_req` is asserted.
- R7: `all_ready` rises on the same edge that stage N-1 is released. It stays high until reset or loss of lock, and whenever it is high all `stage_rst` bits are 0.
- R8: Losing lock during or after the sequence reasserts every `stage_rst` bit and clears `all_ready` on the next edge. When lock returns, the sequence restarts from the lock wait with the timing of R5.
- R9: Asserting `rst_req` after the sequence has completed clears `all_ready` and reasserts all resets on the third edge. On the second edge the outputs are still unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all sequencing logic |
| rst_req | input | 1 | Asynchronous external reset request, active high |
| clk_locked | input | 1 | Lock indication from the clock generator |
| stage_init_ack | input | N_STAGES | Per-module flag, high while the module is in its reset/init state |
| hold_cycles | input | HOLD_W | Minimum number of cycles all resets are held after lock (0 acts as 1) |
| timeout_cycles | input | TMO_W | Per-stage wait limit for the flag (0 acts as 1) |
| stage_rst | output | N_STAGES | Registered per-module reset, 1 = held in reset |
| all_ready | output | 1 | High once every module has been released |
| seq_error | output | 1 | Sticky fault: a module flag did not arrive in time |

## Verification
The bench sweeps hold time, timeout and the index of a silent module over a four-stage configuration, and computes every release edge and fault edge from the formulas in R5 and R6. An off-by-one in the hold or timeout counter would shift every release by a cycle. A controller that ignored the flag would release the silent stage and later ones. A controller that released stages in parallel or out of order would show several bits falling on one edge.

Directed cases cover several situations:
- A long wait for lock, where a design that skipped lock qualification would release early.
- Loss of lock after completion, where a design that latched `all_ready` would keep reporting ready.
- A late but in-time flag, which must release on the edge after it appears rather than fault.
- Reset requests seen through the synchroniser, where a missing flop shifts the reaction by a cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Sequencer states; LOCKWAIT is the restart point.
    typedef enum logic [2:0] {
        SQ_LOCKWAIT = 3'd0,
        SQ_HOLD     = 3'd1,
        SQ_ACKWAIT  = 3'd2,
        SQ_READY    = 3'd3,
        SQ_FAULT    = 3'd4
    } seq_state_e;

    // Decisions the sequencer takes in one cycle.
    typedef struct packed {
        logic hold_tick;    // counting the minimum hold
        logic wait_tick;    // waiting for the current flag
        logic take_stage;   // current flag seen, release it
        logic reassert;     // force every reset back on
    } seq_ctrl_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    // A zero limit behaves as one cycle because cnt_next >= 1 always.
    assign expire   = run && (cnt_next >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (run && !expire) begin
            cnt_q <= cnt_next[W-1:0];
        end
    end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int N_STAGES = 4,
    parameter int HOLD_W   = 8,
    parameter int TMO_W    = 12
) (
    input  logic                clk,
    input  logic                rst_req,
    input  logic                clk_locked,
    input  logic [N_STAGES-1:0] stage_init_ack,
    input  logic [HOLD_W-1:0]   hold_cycles,
    input  logic [TMO_W-1:0]    timeout_cycles,
    output logic [N_STAGES-1:0] stage_rst,
    output logic                all_ready,
    output logic                seq_error
);
    localparam int IW = idx_width(N_STAGES);
    localparam logic [IW-1:0] LAST_IDX = IW'(N_STAGES - 1);

    logic          rst_sync;
    seq_state_e    st_q;
    logic [IW-1:0] idx_q;
    logic          ready_q;
    logic          fault_q;
    logic          ack_cur;
    logic          hold_done;
    logic          wait_expired;
    seq_ctrl_t     ctl;
    logic [N_STAGES-1:0] rst_q;

    rstseq_sync #(.STAGES(2)) u_req_sync (
        .clk      (clk),
        .async_in (rst_req),
        .sync_out (rst_sync)
    );

    assign ack_cur = stage_init_ack[idx_q];

    always_comb begin
        ctl.hold_tick  = (st_q == SQ_HOLD) && clk_locked;
        ctl.wait_tick  = (st_q == SQ_ACKWAIT) && clk_locked && !ack_cur;
        ctl.take_stage = (st_q == SQ_ACKWAIT) && clk_locked && ack_cur;
        ctl.reassert   = rst_sync || !clk_locked || wait_expired;
    end

    rstseq_timer #(.W(HOLD_W)) u_hold_tmr (
        .clk    (clk),
        .clr    (rst_sync || !ctl.hold_tick),
        .run    (ctl.hold_tick),
        .limit  (hold_cycles),
        .expire (hold_done)
    );

    rstseq_timer #(.W(TMO_W)) u_ack_tmr (
        .clk    (clk),
        .clr    (rst_sync || !ctl.wait_tick),
        .run    (ctl.wait_tick),
        .limit  (timeout_cycles),
        .expire (wait_expired)
    );

    // Sequencing state machine
    always_ff @(posedge clk) begin
        if (rst_sync) begin
            st_q    <= SQ_LOCKWAIT;
            idx_q   <= '0;
            ready_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            case (st_q)
                SQ_LOCKWAIT: begin
                    if (clk_locked) st_q <= SQ_HOLD;
                end
                SQ_HOLD: begin
                    if (!clk_locked) begin
                        st_q <= SQ_LOCKWAIT;
                    end else if (hold_done) begin
                        st_q  <= SQ_ACKWAIT;
                        idx_q <= '0;
                    end
                end
                SQ_ACKWAIT: begin
                    if (!clk_locked) begin
                        st_q <= SQ_LOCKWAIT;
                    end else if (ctl.take_stage) begin
                        if (idx_q == LAST_IDX) begin
                            st_q    <= SQ_READY;
                            ready_q <= 1'b1;
                        end else begin
                            idx_q <= idx_q + IW'(1);
                        end
                    end else if (wait_expired) begin
                        st_q    <= SQ_FAULT;
                        fault_q <= 1'b1;
                    end
                end
                SQ_READY: begin
                    if (!clk_locked) begin
                        st_q    <= SQ_LOCKWAIT;
                        ready_q <= 1'b0;
                    end
                end
                SQ_FAULT: st_q <= SQ_FAULT;
                default:  st_q <= SQ_LOCKWAIT;
            endcase
        end
    end

    // Per-stage registered reset outputs
    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (ctl.reassert || st_q == SQ_FAULT) begin
                rst_q[g] <= 1'b1;
            end else if (ctl.take_stage && idx_q == IW'(g)) begin
                rst_q[g] <= 1'b0;
            end
        end

        AST_RELEASE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst_sync)
            $fell(rst_q[g]) |-> $past(stage_init_ack[g]));  // R3

        if (g > 0) begin : g_order
            AST_RELEASE_IN_ORDER: assert property (@(posedge clk) disable iff (rst_sync)
                $fell(rst_q[g]) |-> !rst_q[g-1]);  // R4
        end
    end

    assign stage_rst = rst_q;
    assign all_ready = ready_q;
    assign seq_error = fault_q;

    AST_UNLOCKED_HOLDS_ALL: assert property (@(posedge clk) disable iff (rst_sync)
        !clk_locked |=> (&stage_rst));  // R1
    AST_ONE_RELEASE_PER_EDGE: assert property (@(posedge clk) disable iff (rst_sync)
        $onehot0($past(stage_rst) & ~stage_rst));  // R4
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst_sync)
        seq_error |=> seq_error);  // R6
    AST_FAULT_HOLDS_ALL: assert property (@(posedge clk) disable iff (rst_sync)
        seq_error |-> (&stage_rst));  // R6
    AST_READY_ALL_RELEASED: assert property (@(posedge clk) disable iff (rst_sync)
        all_ready |-> (stage_rst == '0));  // R7
    AST_READY_NOT_FAULT: assert property (@(posedge clk) disable iff (rst_sync)
        !(all_ready && seq_error));  // R7
endmodule

// File: tb/rstseq_ctrl_bench.sv
`timescale 1ns/1ps
module rstseq_ctrl_bench;
    localparam int N  = 4;
    localparam int HW = 4;
    localparam int TW = 4;
    localparam int MAXE = 60;

    logic          clk = 1'b0;
    logic          rst_req = 1'b1;
    logic          clk_locked = 1'b1;
    logic [N-1:0]  ack = '1;
    logic [HW-1:0] hold_cycles = '0;
    logic [TW-1:0] timeout_cycles = '0;
    logic [N-1:0]  stage_rst;
    logic          all_ready;
    logic          seq_error;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    rstseq_ctrl #(.N_STAGES(N), .HOLD_W(HW), .TMO_W(TW)) u_rstseq_ctrl (
        .clk            (clk),
        .rst_req        (rst_req),
        .clk_locked     (clk_locked),
        .stage_init_ack (ack),
        .hold_cycles    (hold_cycles),
        .timeout_cycles (timeout_cycles),
        .stage_rst      (stage_rst),
        .all_ready      (all_ready),
        .seq_error      (seq_error)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Full sequence: h hold, t timeout, f silent stage (N = none), d lock delay edges.
    task automatic run_seq(input int h, input int t, input int f, input int d);
        int rel_at [N];
        int rdy_at, err_at, heff, teff, lk, early;
        heff = (h == 0) ? 1 : h;
        teff = (t == 0) ? 1 : t;
        lk   = (d == 0) ? 3 : ((d + 1 > 3) ? d + 1 : 3);
        @(negedge clk);
        rst_req        = 1'b1;
        clk_locked     = (d == 0);
        ack            = '1;
        if (f < N) ack[f] = 1'b0;
        hold_cycles    = HW'(h);
        timeout_cycles = TW'(t);
        repeat (4) edge_step();
        chk(stage_rst == '1 && !all_ready && !seq_error, "R2 reset state",
            {stage_rst, all_ready, seq_error}, {4'hF, 2'b00});
        rst_req = 1'b0;
        for (int i = 0; i < N; i++) rel_at[i] = -1;
        rdy_at = -1; err_at = -1; early = 0;
        for (int e = 1; e <= MAXE; e++) begin
            edge_step();
            for (int i = 0; i < N; i++)
                if (rel_at[i] < 0 && !stage_rst[i]) rel_at[i] = e;
            if (rdy_at < 0 && all_ready) rdy_at = e;
            if (err_at < 0 && seq_error) err_at = e;
            if (e <= d && stage_rst != '1) early++;
            if (e == d) clk_locked = 1'b1;
        end
        if (d > 0) chk(early == 0, "R1 no release while unlocked", early, 0);
        for (int i = 0; i < N; i++) begin
            if (i < f) chk(rel_at[i] == lk + heff + 1 + i, "R5/R4 release edge", rel_at[i], lk + heff + 1 + i);
            else       chk(rel_at[i] == -1, "R3 stage without flag held", rel_at[i], -1);
        end
        if (f == N) begin
            chk(rdy_at == lk + heff + N, "R7 ready edge", rdy_at, lk + heff + N);
            chk(err_at == -1, "R6 no fault", err_at, -1);
            chk(all_ready && stage_rst == '0, "R7 ready stays", all_ready, 1);
        end else begin
            chk(err_at == lk + heff + f + teff, "R6 fault edge", err_at, lk + heff + f + teff);
            chk(rdy_at == -1, "R7 no ready on fault", rdy_at, -1);
            chk(stage_rst == '1, "R6 resets reasserted", stage_rst, 4'hF);
            clk_locked = 1'b0;
            repeat (3) edge_step();
            chk(seq_error == 1'b1, "R6 fault sticky over lock loss", seq_error, 1);
            clk_locked = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int hs [5] = '{0, 1, 2, 5, 9};
        int ts [3] = '{1, 3, 6};
        int rel_at [N];
        int heff;
        // Sweep hold, timeout and silent stage
        foreach (hs[a]) foreach (ts[b])
            for (int f = 0; f <= N; f++) run_seq(hs[a], ts[b], f, 0);
        // R1: long lock wait
        run_seq(2, 3, N, 20);
        run_seq(0, 2, 1, 7);
        // R8: lock loss after completion, then restart
        run_seq(3, 4, N, 0);
        clk_locked = 1'b0;
        edge_step();
        chk(stage_rst == '1, "R8 resets on lock loss", stage_rst, 4'hF);
        chk(!all_ready, "R8 ready cleared", all_ready, 0);
        repeat (2) edge_step();
        clk_locked = 1'b1;
        heff = 3;
        for (int i = 0; i < N; i++) rel_at[i] = -1;
        for (int e = 1; e <= 20; e++) begin
            edge_step();
            for (int i = 0; i < N; i++)
                if (rel_at[i] < 0 && !stage_rst[i]) rel_at[i] = e;
        end
        for (int i = 0; i < N; i++)
            chk(rel_at[i] == 1 + heff + 1 + i, "R8 restart release edge", rel_at[i], 2 + heff + i);
        chk(all_ready, "R8 ready again", all_ready, 1);
        // R9: reset request after completion, through the synchroniser
        rst_req = 1'b1;
        repeat (2) edge_step();
        chk(all_ready && stage_rst == '0, "R9 no reaction on second edge", all_ready, 1);
        edge_step();
        chk(!all_ready && stage_rst == '1, "R9 reset on third edge", all_ready, 0);
        // R3: flag arrives late but within the timeout
        hold_cycles = 4'd1; timeout_cycles = 4'd6; ack = 4'b1110;
        repeat (2) edge_step();
        rst_req = 1'b0;
        for (int i = 0; i < N; i++) rel_at[i] = -1;
        for (int e = 1; e <= 20; e++) begin
            edge_step();
            for (int i = 0; i < N; i++)
                if (rel_at[i] < 0 && !stage_rst[i]) rel_at[i] = e;
            if (e == 6) ack[0] = 1'b1;
        end
        for (int i = 0; i < N; i++)
            chk(rel_at[i] == 7 + i, "R3 late flag release edge", rel_at[i], 7 + i);
        chk(!seq_error, "R6 late flag no fault", seq_error, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule